// File: doc/BRIEF.md
# Gated JTAG Test Access Port

This block is a boundary-scan test access port for a configurable logic device. It holds the standard sixteen-state TAP controller, a five-bit instruction register with its decoder, and a set of data registers: a one-bit bypass stage, a 32-bit identification word, a 32-bit user code word, and a boundary register. The boundary register gives every pad cell three bits: captured pin input, core output value and core output enable. Every pad, whether bonded or not and whatever its functional direction, sits in one serial chain as a three-state bidirectional cell. Two further user scan chains are exported as data-register ports. Each has its own select line and its own capture, shift and update strobes, and returns a serial bit that the block routes to TDO.

The two user-chain instructions are refused until the device reports that configuration is complete. While `cfg_done` is low, an instruction register holding either user opcode acts exactly as BYPASS and no user strobe fires. Once `cfg_done` is high, every instruction can be used. In the pad-test modes the pad outputs and the core inputs are taken from the boundary update latches. The HIGHZ instruction turns every output enable off.

Top module: `tap_gated_top`

## Requirements
- R1: The controller walks the sixteen TAP states on rising `tck` under `tms`. Five consecutive rising edges with `tms` high, from any state, reach Test-Logic-Reset. Driving `trst_n` low forces Test-Logic-Reset asynchronously, and the release of `trst_n` is synchronised to `tck`.
- R2: Test-Logic-Reset loads the IDCODE instruction. Under IDCODE, Capture-DR loads the 32-bit parameter `IDCODE_VAL`, whose bit 0 is 1, and Shift-DR sends it out LSB first.
- R3: The instruction register is 5 bits wide and shifts LSB first. Capture-IR loads 0b00001. A shifted opcode takes effect only after Update-IR and is held everywhere else.
- R4: The opcodes are EXTEST 0x00, SAMPLE/PRELOAD 0x01, USER1 0x02, USER2 0x03, INTEST 0x07, USERCODE 0x08, IDCODE 0x09, HIGHZ 0x0A and BYPASS 0x1F. Every other 5-bit code behaves as BYPASS.
- R5: Under BYPASS the data path is one stage that captures 0, so TDO repeats TDI one shift later.
- R6: Under USERCODE, Capture-DR loads the 32-bit parameter `USERCODE_VAL`, which then shifts out LSB first.
- R7: While `cfg_done` is low, opcodes 0x02 and 0x03 act as BYPASS and all user select and strobe outputs stay low.
- R8: With `cfg_done` high, USER1 drives bit 0 and USER2 drives bit 1 of `usr_sel`. For the selected chain, the matching bit of `usr_capture`, `usr_shift` or `usr_update` is high during Capture-DR, Shift-DR or Update-DR. During the shift, TDO carries that chain's `usr_ret` bit. At most one chain is selected at a time.
- R9: The boundary register is 3×`N_PADS` bits long and shifts LSB first. Bit 3i holds `pad_pin_in[i]`, bit 3i+1 holds `core_out[i]` and bit 3i+2 holds `core_oe[i]`. These are captured in Capture-DR under EXTEST, SAMPLE/PRELOAD or INTEST.
- R10: The boundary update latches load from the boundary register only in Update-DR under EXTEST, SAMPLE/PRELOAD or INTEST. They keep their value during shifting and under any other instruction.
- R11: Under EXTEST, `pad_out[i]` and `pad_oe[i]` come from latch bits 3i+1 and 3i+2. Under INTEST, `core_in[i]` comes from latch bit 3i. In every other case the pad and core signals pass straight through.
- R12: Under HIGHZ every `pad_oe` bit is 0 and the data path is the bypass stage.
- R13: TDO and `tdo_en` change on falling `tck`. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid while `tdo_en` is high |
| tdo_en | output | 1 | TDO driver enable |
| cfg_done | input | 1 | Device configuration complete |
| pad_pin_in | input | N_PADS | Value seen on each pad pin |
| core_out | input | N_PADS | Output value the core drives to each pad |
| core_oe | input | N_PADS | Output enable the core drives to each pad |
| core_in | output | N_PADS | Pin value delivered to the core |
| pad_out | output | N_PADS | Output value applied to each pad |
| pad_oe | output | N_PADS | Output enable applied to each pad |
| usr_sel | output | 2 | User chain selects (bit 0 USER1, bit 1 USER2) |
| usr_capture | output | 2 | User chain capture strobes |
| usr_shift | output | 2 | User chain shift strobes |
| usr_update | output | 2 | User chain update strobes |
| usr_ret | input | 2 | Serial return bit of each user chain |

## Verification
The assertions assume that `tms` and `tdi` change only away from the rising edge of `tck`, and that `trst_n` is low long enough to reset the controller before the first scan. They also assume that `cfg_done` does not toggle in the middle of a data scan, because the gate is decoded combinationally. The stimulus meets these conditions: all inputs are driven shortly after a falling edge, `trst_n` is held low for several cycles at the start and whenever it is pulsed, and `cfg_done` and the pad inputs change only while the controller waits in Run-Test/Idle. The opcode sweep runs every 5-bit code with the gate both open and closed, and uses fixed pad inputs so that the captured boundary words are known in advance.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    TS_EXIT2_DR = 4'h0,
    TS_EXIT1_DR = 4'h1,
    TS_SHIFT_DR = 4'h2,
    TS_PAUSE_DR = 4'h3,
    TS_SEL_IR   = 4'h4,
    TS_UPD_DR   = 4'h5,
    TS_CAP_DR   = 4'h6,
    TS_SEL_DR   = 4'h7,
    TS_EXIT2_IR = 4'h8,
    TS_EXIT1_IR = 4'h9,
    TS_SHIFT_IR = 4'hA,
    TS_PAUSE_IR = 4'hB,
    TS_IDLE     = 4'hC,
    TS_UPD_IR   = 4'hD,
    TS_CAP_IR   = 4'hE,
    TS_RESET    = 4'hF
  } tap_state_e;

  localparam int unsigned IR_W = 5;

  localparam logic [IR_W-1:0] OP_EXTEST   = 5'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 5'h01;
  localparam logic [IR_W-1:0] OP_USER1    = 5'h02;
  localparam logic [IR_W-1:0] OP_USER2    = 5'h03;
  localparam logic [IR_W-1:0] OP_INTEST   = 5'h07;
  localparam logic [IR_W-1:0] OP_USERCODE = 5'h08;
  localparam logic [IR_W-1:0] OP_IDCODE   = 5'h09;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 5'h0A;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 5'h01;

  typedef enum logic [2:0] {
    DR_BYPASS,
    DR_IDCODE,
    DR_USERCODE,
    DR_BOUNDARY,
    DR_USER1,
    DR_USER2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr;
    logic    extest;
    logic    intest;
    logic    highz;
    logic    bsr_upd_en;
  } ir_dec_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end

  // R1: five TMS-high edges in a row always end in Test-Logic-Reset
  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == TS_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  logic       cfg_done,
  output ir_dec_t    dec,
  output logic       ir_tdo
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_sr_d;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_q_d;
  logic            sr_en;
  logic            ir_en;

  always_comb begin
    sr_en   = 1'b0;
    ir_sr_d = ir_sr;
    if (state == TS_CAP_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = IR_CAPTURE;
    end else if (state == TS_SHIFT_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en  = 1'b0;
    ir_q_d = ir_q;
    if (state == TS_RESET) begin
      ir_en  = 1'b1;
      ir_q_d = OP_IDCODE;
    end else if (state == TS_UPD_IR) begin
      ir_en  = 1'b1;
      ir_q_d = ir_sr;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPTURE;
    else if (sr_en) ir_sr <= ir_sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_q_d;
  end

  assign ir_tdo = ir_sr[0];

  // Decode, with the two user opcodes refused until configuration is done
  always_comb begin
    dec.dr         = DR_BYPASS;
    dec.extest     = 1'b0;
    dec.intest     = 1'b0;
    dec.highz      = 1'b0;
    dec.bsr_upd_en = 1'b0;
    case (ir_q)
      OP_EXTEST: begin
        dec.dr         = DR_BOUNDARY;
        dec.extest     = 1'b1;
        dec.bsr_upd_en = 1'b1;
      end
      OP_SAMPLE: begin
        dec.dr         = DR_BOUNDARY;
        dec.bsr_upd_en = 1'b1;
      end
      OP_INTEST: begin
        dec.dr         = DR_BOUNDARY;
        dec.intest     = 1'b1;
        dec.bsr_upd_en = 1'b1;
      end
      OP_IDCODE:   dec.dr = DR_IDCODE;
      OP_USERCODE: dec.dr = DR_USERCODE;
      OP_HIGHZ:    dec.highz = 1'b1;
      OP_USER1:    if (cfg_done) dec.dr = DR_USER1;
      OP_USER2:    if (cfg_done) dec.dr = DR_USER2;
      default:     dec.dr = DR_BYPASS;
    endcase
  end

  // R3: Capture-IR leaves the fixed pattern in the shift stage
  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  // R3: the active instruction moves only in Update-IR or Test-Logic-Reset
  a_r3_ir_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !(state == TS_UPD_IR || state == TS_RESET) |=> $stable(ir_q));

  // R2: Test-Logic-Reset selects the identification instruction
  a_r2_reset_idcode: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_const_dr.sv
module tap_const_dr #(
  parameter int unsigned       W     = 32,
  parameter logic [W-1:0]      VALUE = '0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  output logic sr_tdo
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (sel && capture) begin
      sr_en = 1'b1;
      sr_d  = VALUE;
    end else if (sel && shift) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr_tdo = sr_q[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import jtag_tap_pkg::*;
#(
  parameter int unsigned N_PADS = 4
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  ir_dec_t           dec,
  input  logic [N_PADS-1:0] pad_pin_in,
  input  logic [N_PADS-1:0] core_out,
  input  logic [N_PADS-1:0] core_oe,
  output logic [N_PADS-1:0] core_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe,
  output logic              bsr_tdo
);

  localparam int unsigned CELL_W = 3;
  localparam int unsigned BSR_W  = CELL_W * N_PADS;
  localparam int unsigned B_IN   = 0;
  localparam int unsigned B_OUT  = 1;
  localparam int unsigned B_OE   = 2;

  logic [BSR_W-1:0] cap_vec;
  logic [BSR_W-1:0] sr_q;
  logic [BSR_W-1:0] sr_d;
  logic [BSR_W-1:0] upd_q;
  logic             sr_en;
  logic             upd_en;
  logic             sel;

  assign sel = (dec.dr == DR_BOUNDARY);

  for (genvar i = 0; i < N_PADS; i++) begin : g_cell
    assign cap_vec[CELL_W*i + B_IN]  = pad_pin_in[i];
    assign cap_vec[CELL_W*i + B_OUT] = core_out[i];
    assign cap_vec[CELL_W*i + B_OE]  = core_oe[i];

    assign pad_out[i] = dec.extest ? upd_q[CELL_W*i + B_OUT] : core_out[i];
    assign pad_oe[i]  = dec.highz  ? 1'b0
                      : dec.extest ? upd_q[CELL_W*i + B_OE] : core_oe[i];
    assign core_in[i] = dec.intest ? upd_q[CELL_W*i + B_IN] : pad_pin_in[i];
  end

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (sel && state == TS_CAP_DR) begin
      sr_en = 1'b1;
      sr_d  = cap_vec;
    end else if (sel && state == TS_SHIFT_DR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[BSR_W-1:1]};
    end
  end

  assign upd_en = dec.bsr_upd_en && (state == TS_UPD_DR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      upd_q <= '0;
    else if (upd_en) upd_q <= sr_q;
  end

  assign bsr_tdo = sr_q[0];

  // R10: update latches hold outside Update-DR
  a_r10_latch_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (state != TS_UPD_DR) |=> $stable(upd_q));

  // R9: the shift stage keeps its contents when the boundary path is not selected
  a_r9_unselected_hold: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |=> $stable(sr_q));

endmodule

// File: rtl/tap_gated_top.sv
module tap_gated_top
  import jtag_tap_pkg::*;
#(
  parameter int unsigned N_PADS       = 4,
  parameter logic [31:0] IDCODE_VAL   = 32'h1A5C_3E07,
  parameter logic [31:0] USERCODE_VAL = 32'hC0DE_0F15
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic              cfg_done,
  input  logic [N_PADS-1:0] pad_pin_in,
  input  logic [N_PADS-1:0] core_out,
  input  logic [N_PADS-1:0] core_oe,
  output logic [N_PADS-1:0] core_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe,
  output logic [1:0]        usr_sel,
  output logic [1:0]        usr_capture,
  output logic [1:0]        usr_shift,
  output logic [1:0]        usr_update,
  input  logic [1:0]        usr_ret
);

  localparam int unsigned N_CONST = 2;
  localparam int unsigned CONST_W = 32;

  logic       rst_meta;
  logic       rst_n;
  tap_state_e state;
  ir_dec_t    dec;
  logic       ir_tdo;
  logic       bsr_tdo;
  logic       bypass_q;
  logic       bypass_d;
  logic       bypass_en;
  logic       cap_dr;
  logic       shift_dr;
  logic       upd_dr;
  logic [N_CONST-1:0] cdr_tdo;
  logic       dr_tdo;
  logic       tdo_d;
  logic       tdo_en_d;

  // Asynchronous assertion, release synchronised to tck
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck      (tck),
    .rst_n    (rst_n),
    .tdi      (tdi),
    .state    (state),
    .cfg_done (cfg_done),
    .dec      (dec),
    .ir_tdo   (ir_tdo)
  );

  tap_bsr #(.N_PADS(N_PADS)) u_bsr (
    .tck        (tck),
    .rst_n      (rst_n),
    .tdi        (tdi),
    .state      (state),
    .dec        (dec),
    .pad_pin_in (pad_pin_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .core_in    (core_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .bsr_tdo    (bsr_tdo)
  );

  assign cap_dr   = (state == TS_CAP_DR);
  assign shift_dr = (state == TS_SHIFT_DR);
  assign upd_dr   = (state == TS_UPD_DR);

  for (genvar g = 0; g < N_CONST; g++) begin : g_const
    localparam logic [CONST_W-1:0] CVAL = (g == 0) ? IDCODE_VAL : USERCODE_VAL;
    logic csel;
    assign csel = (g == 0) ? (dec.dr == DR_IDCODE) : (dec.dr == DR_USERCODE);
    tap_const_dr #(.W(CONST_W), .VALUE(CVAL)) u_cdr (
      .tck     (tck),
      .rst_n   (rst_n),
      .tdi     (tdi),
      .sel     (csel),
      .capture (cap_dr),
      .shift   (shift_dr),
      .sr_tdo  (cdr_tdo[g])
    );
  end

  // One-stage bypass path
  always_comb begin
    bypass_en = 1'b0;
    bypass_d  = bypass_q;
    if (dec.dr == DR_BYPASS && cap_dr) begin
      bypass_en = 1'b1;
      bypass_d  = 1'b0;
    end else if (dec.dr == DR_BYPASS && shift_dr) begin
      bypass_en = 1'b1;
      bypass_d  = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         bypass_q <= 1'b0;
    else if (bypass_en) bypass_q <= bypass_d;
  end

  // User chain strobes
  assign usr_sel[0] = (dec.dr == DR_USER1);
  assign usr_sel[1] = (dec.dr == DR_USER2);
  for (genvar k = 0; k < 2; k++) begin : g_user
    assign usr_capture[k] = usr_sel[k] && cap_dr;
    assign usr_shift[k]   = usr_sel[k] && shift_dr;
    assign usr_update[k]  = usr_sel[k] && upd_dr;
  end

  // Serial output selection, registered on falling tck
  always_comb begin
    case (dec.dr)
      DR_IDCODE:   dr_tdo = cdr_tdo[0];
      DR_USERCODE: dr_tdo = cdr_tdo[1];
      DR_BOUNDARY: dr_tdo = bsr_tdo;
      DR_USER1:    dr_tdo = usr_ret[0];
      DR_USER2:    dr_tdo = usr_ret[1];
      default:     dr_tdo = bypass_q;
    endcase
    tdo_d    = (state == TS_SHIFT_IR) ? ir_tdo : dr_tdo;
    tdo_en_d = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  // R7: no user select while configuration is incomplete
  a_r7_gate_closed: assert property (@(posedge tck) disable iff (!rst_n)
    !cfg_done |-> (usr_sel == 2'b00));

  // R8: at most one user chain is selected
  a_r8_one_chain: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(usr_sel));

  // R12: HIGHZ leaves no pad enabled
  a_r12_highz_off: assert property (@(posedge tck) disable iff (!rst_n)
    dec.highz |-> (pad_oe == '0));

  // R13: the output driver is on only while a shift state was active
  a_r13_tdo_en_shift: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == TS_SHIFT_DR || state == TS_SHIFT_IR));

endmodule

// File: tb/sim_tap_gated_top.sv
`timescale 1ns/1ps
module sim_tap_gated_top;

  localparam int NP = 4;
  localparam int BW = 3 * NP;
  localparam logic [31:0] ID_V = 32'h1A5C_3E07;
  localparam logic [31:0] UC_V = 32'hC0DE_0F15;
  localparam int SW = 48;

  logic          tck = 1'b0;
  logic          trst_n;
  logic          tms;
  logic          tdi;
  logic          tdo;
  logic          tdo_en;
  logic          cfg_done;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] c_out;
  logic [NP-1:0] c_oe;
  logic [NP-1:0] core_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [1:0]    usr_sel;
  logic [1:0]    usr_capture;
  logic [1:0]    usr_shift;
  logic [1:0]    usr_update;
  logic [1:0]    usr_ret;

  int total = 0;
  int bad = 0;
  int en_err = 0;
  int cnt_cap[2];
  int cnt_sh[2];
  int cnt_up[2];
  int sel_seen[2];
  logic [NP-1:0] mid_pad_out;
  logic [NP-1:0] mid_pad_oe;
  bit done = 0;

  always #5 tck = ~tck;

  tap_gated_top #(.N_PADS(NP), .IDCODE_VAL(ID_V), .USERCODE_VAL(UC_V)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .cfg_done(cfg_done), .pad_pin_in(pin_in), .core_out(c_out), .core_oe(c_oe),
    .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe), .usr_sel(usr_sel),
    .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_update(usr_update),
    .usr_ret(usr_ret)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One tck cycle: observe outputs after the falling edge, then drive inputs
  task automatic step(input logic m, input logic d, input logic exp_en, output logic o);
    @(negedge tck);
    #2;
    o = tdo;
    if (tdo_en !== exp_en) en_err++;
    for (int k = 0; k < 2; k++) begin
      if (usr_capture[k]) cnt_cap[k]++;
      if (usr_shift[k])   cnt_sh[k]++;
      if (usr_update[k])  cnt_up[k]++;
      if (usr_sel[k])     sel_seen[k]++;
    end
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic clr_cnt();
    for (int k = 0; k < 2; k++) begin
      cnt_cap[k] = 0; cnt_sh[k] = 0; cnt_up[k] = 0; sel_seen[k] = 0;
    end
  endtask

  // From Run-Test/Idle to Run-Test/Idle
  task automatic ir_scan(input logic [4:0] op, output logic [4:0] got);
    logic o;
    step(1, 0, 0, o);
    step(1, 0, 0, o);
    step(0, 0, 0, o);
    step(0, 0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i], 1, o);
      got[i] = o;
    end
    step(1, 0, 0, o);
    step(0, 0, 0, o);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1, 0, 0, o);
    step(0, 0, 0, o);
    step(0, 0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], 1, o);
      dout[i] = o;
    end
    mid_pad_out = pad_out;
    mid_pad_oe  = pad_oe;
    step(1, 0, 0, o);
    step(0, 0, 0, o);
  endtask

  function automatic logic [BW-1:0] cap_word();
    logic [BW-1:0] w;
    for (int i = 0; i < NP; i++) begin
      w[3*i]   = pin_in[i];
      w[3*i+1] = c_out[i];
      w[3*i+2] = c_oe[i];
    end
    return w;
  endfunction

  function automatic logic [NP-1:0] pick(input logic [BW-1:0] p, input int off);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = p[3*i+off];
    return r;
  endfunction

  // 0 bypass, 1 id, 2 usercode, 3 boundary, 4 user1, 5 user2 (R4, R7)
  function automatic int op_class(input logic [4:0] op, input logic cfg);
    case (op)
      5'h00, 5'h01, 5'h07: return 3;
      5'h09: return 1;
      5'h08: return 2;
      5'h02: return cfg ? 4 : 0;
      5'h03: return cfg ? 5 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_scan(input int cls, input logic [63:0] din);
    logic [63:0] r;
    case (cls)
      1: r = {din[31:0], ID_V};
      2: r = {din[31:0], UC_V};
      3: r = (din << BW) | 64'(cap_word());
      4: r = {64{usr_ret[0]}};
      5: r = {64{usr_ret[1]}};
      default: r = {din[62:0], 1'b0};
    endcase
    return r & ((64'd1 << SW) - 1);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0]  g5;
    logic [63:0] dout;
    logic [63:0] din;
    logic [BW-1:0] p1;
    logic [BW-1:0] p2;
    logic o;
    trst_n = 0; tms = 1; tdi = 0; cfg_done = 0;
    pin_in = 4'b1010; c_out = 4'b0110; c_oe = 4'b1100; usr_ret = 2'b10;
    clr_cnt();
    repeat (4) @(posedge tck);
    @(negedge tck);
    trst_n = 1;
    repeat (3) @(posedge tck);
    #1;

    // Reset state (R13, R11, R7)
    chk("R13 reset tdo_en", 64'(tdo_en), 64'd0);
    chk("R11 reset pad passthrough", {pad_oe, pad_out, core_in}, {c_oe, c_out, pin_in});
    chk("R7 reset usr_sel", 64'(usr_sel), 64'd0);

    step(0, 0, 0, o);
    // R2: identification word after reset
    dr_scan(32, 64'h0, dout);
    chk("R2 idcode after reset", dout[31:0], ID_V);

    // R3: capture pattern of the instruction register
    ir_scan(5'h1F, g5);
    chk("R3 ir capture", 64'(g5), 64'h01);
    // R5: bypass one-stage delay
    din = 64'h0000_00A5_3C96_F00F;
    dr_scan(SW, din, dout);
    chk("R5 bypass delay", dout & ((64'd1 << SW) - 1), {din[62:0], 1'b0} & ((64'd1 << SW) - 1));

    // Sweep of every opcode with the gate closed and open (R4, R6, R7, R8, R9, R12)
    for (int c = 0; c < 2; c++) begin
      cfg_done = c[0];
      for (int op = 0; op < 32; op++) begin
        int cls;
        logic [63:0] es;
        logic [63:0] as;
        ir_scan(op[4:0], g5);
        clr_cnt();
        din = {32'h5AC3_19E7 ^ 32'(op * 7919), 32'h96F0_2D4B ^ 32'(op)};
        dr_scan(SW, din, dout);
        cls = op_class(op[4:0], c[0]);
        chk($sformatf("R4 R6 R9 op=%0h cfg=%0d scan", op, c), dout & ((64'd1 << SW) - 1),
            exp_scan(cls, din));
        as = {8'(cnt_cap[0]), 8'(cnt_sh[0]), 8'(cnt_up[0]),
              8'(cnt_cap[1]), 8'(cnt_sh[1]), 8'(cnt_up[1])};
        es = '0;
        if (cls == 4) es = {8'd1, 8'(SW), 8'd1, 24'd0};
        if (cls == 5) es = {24'd0, 8'd1, 8'(SW), 8'd1};
        chk($sformatf("R7 R8 op=%0h cfg=%0d strobes", op, c), as, es);
        if (op == 10) chk("R12 highz pad_oe", 64'(pad_oe), 64'd0);
      end
    end
    cfg_done = 1;

    // Boundary preload, then external test (R10, R11)
    p1 = 12'b101_011_110_001;
    p2 = 12'b010_110_001_111;
    ir_scan(5'h01, g5);
    dr_scan(BW, 64'(p1), dout);
    chk("R11 sample passthrough", {pad_oe, pad_out}, {c_oe, c_out});
    ir_scan(5'h00, g5);
    chk("R11 extest pads from latches", {pad_oe, pad_out}, {pick(p1, 2), pick(p1, 1)});
    dr_scan(BW, 64'(p2), dout);
    chk("R10 latches hold during shift", {mid_pad_oe, mid_pad_out}, {pick(p1, 2), pick(p1, 1)});
    chk("R10 latches load at update", {pad_oe, pad_out}, {pick(p2, 2), pick(p2, 1)});
    ir_scan(5'h07, g5);
    chk("R11 intest core_in from latches", 64'(core_in), 64'(pick(p2, 0)));
    chk("R11 intest pad passthrough", {pad_oe, pad_out}, {c_oe, c_out});
    ir_scan(5'h0A, g5);
    chk("R12 highz all enables off", 64'(pad_oe), 64'd0);
    ir_scan(5'h1F, g5);
    dr_scan(BW, 64'(~p2), dout);
    ir_scan(5'h00, g5);
    chk("R10 bypass scan leaves latches", {pad_oe, pad_out}, {pick(p2, 2), pick(p2, 1)});

    // R1: five TMS-high edges from Shift-DR
    ir_scan(5'h1F, g5);
    step(1, 0, 0, o);
    step(0, 0, 0, o);
    step(0, 0, 0, o);
    step(0, 0, 1, o);
    for (int i = 0; i < 5; i++) step(1, 0, i == 0, o);
    step(0, 0, 0, o);
    dr_scan(32, 64'h0, dout);
    chk("R1 tms reset restores idcode", dout[31:0], ID_V);

    // R1: asynchronous test reset
    ir_scan(5'h08, g5);
    @(negedge tck);
    trst_n = 0;
    #1;
    chk("R1 trst tdo_en", 64'(tdo_en), 64'd0);
    repeat (3) @(posedge tck);
    @(negedge tck);
    trst_n = 1;
    tms = 1;
    repeat (3) @(posedge tck);
    #1;
    step(0, 0, 0, o);
    dr_scan(32, 64'h0, dout);
    chk("R1 trst restores idcode", dout[31:0], ID_V);

    // R13: enable followed the shift states in every observed cycle
    chk("R13 tdo_en only in shift", 64'(en_err), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule